// File: doc/BRIEF.md
# Low-Power Mode and Wake-Up Controller

This block is the system-control state machine of a small microcontroller. Software programs two 8-bit control registers over a plain register write strobe with a select line. Through them it chooses the oscillators, the system clock source, and the halt modes. Those modes are: CPU halted with peripherals running, CPU and peripheral clock halted, and full STOP. In STOP both oscillators are switched off. The block then waits on a dedicated wake pin, sensed on a rising edge or on a high level. When the pin releases STOP, the block re-enables the oscillator it is returning to. It counts a programmable number of that oscillator's clock ticks so the oscillator can settle. It then resumes in either the fast-clock or the slow-clock run mode.

The oscillators, the CPU core and the peripheral clock tree are outside the block. They appear only as enable and clock-select outputs. Each oscillator's settled clock is seen as a one-cycle tick input in the controller's own clock domain. The register bus has no back-pressure: a write strobe is either taken in the cycle it is seen or dropped. It is dropped while the CPU is halted. A write to the clock register that would leave the system without a usable clock is never applied. Instead the block raises an internal reset request for one cycle and returns both registers to their reset values.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, register 0 reads 0x00, register 1 reads 0x80, `mode_o` is 0 (fast run), the fast oscillator is enabled, the slow oscillator is disabled, the CPU and peripheral clock run, `port_oe` is 1, `pin_hiz` is 0 and `sys_rst_req` is 0.
- R2: Register 0 stores fields in these bit positions: bit 7 STOP, bit 6 release method, bit 5 return mode, bit 4 port hold, bits 3:2 warm-up code. Register 1 stores fields in these bit positions: bit 7 fast oscillator on, bit 6 slow oscillator on, bit 5 system clock (1 = slow), bit 4 CPU halt, bit 2 peripheral clock halt. Register 0 bits 1:0 and register 1 bits 3, 1 and 0 always read 0.
- R3: Writing 1 to register 0 bit 7 starts STOP. `mode_o` then reads 4, both oscillator enables are 0, `cpu_run` is 0 and `periph_clk_en` is 0.
- R4: With the release method set to 0, only a rising edge of `stop_pin` seen while in STOP ends STOP. A pin that is already high at entry, or that stays constant, keeps the block in STOP.
- R5: With the release method set to 1, a high level on `stop_pin` ends STOP.
- R6: After release, `mode_o` reads 5 (warm-up) for exactly N ticks of the target oscillator (`hf_tick` for return mode 0, `lf_tick` for return mode 1). N = m·2^max(e−WU_SHIFT,0). Here m is 3 for an even code and 1 for an odd code. The exponent e is 16 or 14 for the fast return (codes 0–1 and 2–3), and 13 or 6 for the slow return.
- R7: At the end of warm-up the STOP bit clears. Return mode 0 gives fast run, with register 1 reading 0x80 and `mode_o` 0. Return mode 1 gives slow run, with register 1 reading 0x60 and `mode_o` 1.
- R8: Asserting `rst_n` during STOP returns the block to fast run with the reset register values, regardless of the return-mode bit.
- R9: During STOP and warm-up, `port_oe` equals the port-hold bit and `pin_hiz` is 1. Outside STOP, `port_oe` is 1 and `pin_hiz` is 0.
- R10: A write to register 1 is illegal in three cases: both oscillator bits are 0; bit 7 is 0 while bit 5 is 0; or bit 6 is 0 while bit 5 is 1. Such a write pulses `sys_rst_req` for one cycle and restores both registers to their reset values.
- R11: Register 1 bit 4 halts the CPU (`mode_o` 2 on the fast clock, 3 on the slow clock). Bit 2 halts both the CPU and the peripheral clock. A `wake_irq` pulse clears both bits and resumes running.
- R12: A write to register 1 with bits 4 and 2 both set stores bit 2 as 0.
- R13: Register writes are ignored while STOP is pending or active, during warm-up, and while the CPU is halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | External reset pin, active low, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 mode register, 1 clock register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| stop_pin | input | 1 | Wake pin that ends STOP |
| wake_irq | input | 1 | Interrupt that ends CPU/peripheral halt |
| hf_tick | input | 1 | One-cycle tick of the fast oscillator |
| lf_tick | input | 1 | One-cycle tick of the slow oscillator |
| hf_osc_en | output | 1 | Fast oscillator enable |
| lf_osc_en | output | 1 | Slow oscillator enable |
| sysclk_sel | output | 1 | System clock source, 1 = slow |
| cpu_run | output | 1 | CPU and watchdog clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| port_oe | output | 1 | Port output enable for ordinary pins |
| pin_hiz | output | 1 | Wake pin forced to high impedance |
| sys_rst_req | output | 1 | Internal reset request pulse |
| mode_o | output | 3 | 0 fast, 1 slow, 2 halt on fast, 3 halt on slow, 4 STOP, 5 warm-up |

## Verification
The hardest case to reach is the warm-up count itself. The bench must show that the block counts only the target oscillator's ticks, and that for every code and return clock it leaves warm-up after exactly the table count. The bench builds the block with a large exponent shift so that every table entry stays short. It drives both tick inputs with independent random patterns, tallies the target ticks the block sees while `mode_o` reads warm-up, and compares the tally with the table. Random register writes cover all three illegal-clock conditions. Directed runs reach the edge-release corner, in which the pin is already high when STOP starts.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {ST_RUN, ST_STOP, ST_WARM} stop_st_e;

  localparam logic [2:0] MD_FAST  = 3'd0;
  localparam logic [2:0] MD_SLOW  = 3'd1;
  localparam logic [2:0] MD_HALTF = 3'd2;
  localparam logic [2:0] MD_HALTS = 3'd3;
  localparam logic [2:0] MD_STOP  = 3'd4;
  localparam logic [2:0] MD_WARM  = 3'd5;

  typedef struct packed {
    logic       stop;
    logic       lvl_rel;
    logic       ret_slow;
    logic       hold;
    logic [1:0] wcode;
  } modereg_t;

  typedef struct packed {
    logic hf_on;
    logic lf_on;
    logic clk_slow;
    logic cpu_halt;
    logic per_halt;
  } clkreg_t;

  localparam clkreg_t CLK_RST = '{hf_on: 1'b1, default: 1'b0};

  // Warm-up length in target-oscillator ticks, exponent reduced by shift.
  function automatic logic [31:0] warm_ticks(input logic slow,
                                             input logic [1:0] code,
                                             input int unsigned shift);
    int unsigned e;
    logic [31:0] m;
    if (slow) e = code[1] ? 6 : 13;
    else      e = code[1] ? 14 : 16;
    m = code[0] ? 32'd1 : 32'd3;
    e = (e > shift) ? e - shift : 0;
    return m << e;
  endfunction

endpackage

// File: rtl/pmc_regs.sv
module pmc_regs
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       sel,
  input  logic [7:0] wdata,
  input  logic       accept,
  input  logic       wake_irq,
  input  logic       wake_ok,
  input  logic       warm_done,
  output logic [7:0] rdata,
  output modereg_t   mreg,
  output clkreg_t    creg,
  output logic       rst_req
);

  logic illegal;
  logic wr_ok;
  logic unused_bits;

  assign unused_bits = ^{wdata[3], wdata[1:0]};
  assign wr_ok = we & accept;
  assign illegal = wr_ok & sel &
                   ((~wdata[7] & ~wdata[6]) |
                    (~wdata[7] & ~wdata[5]) |
                    (~wdata[6] &  wdata[5]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mreg    <= '0;
      creg    <= CLK_RST;
      rst_req <= 1'b0;
    end else begin
      rst_req <= illegal;
      if (illegal) begin
        mreg <= '0;
        creg <= CLK_RST;
      end else if (warm_done) begin
        mreg.stop     <= 1'b0;
        creg.hf_on    <= ~mreg.ret_slow;
        creg.lf_on    <= mreg.ret_slow;
        creg.clk_slow <= mreg.ret_slow;
        creg.cpu_halt <= 1'b0;
        creg.per_halt <= 1'b0;
      end else if (wr_ok) begin
        if (!sel) begin
          mreg <= modereg_t'(wdata[7:2]);
        end else begin
          creg.hf_on    <= wdata[7];
          creg.lf_on    <= wdata[6];
          creg.clk_slow <= wdata[5];
          creg.cpu_halt <= wdata[4];
          creg.per_halt <= wdata[2] & ~wdata[4];
        end
      end else if (wake_irq && wake_ok) begin
        creg.cpu_halt <= 1'b0;
        creg.per_halt <= 1'b0;
      end
    end
  end

  always_comb begin
    if (sel) rdata = {creg.hf_on, creg.lf_on, creg.clk_slow, creg.cpu_halt,
                      1'b0, creg.per_halt, 2'b00};
    else     rdata = {mreg, 2'b00};
  end

  AST_RST_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (creg == CLK_RST && mreg == '0)); // R10
  AST_NO_DUAL_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    !(creg.cpu_halt && creg.per_halt)); // R12
  AST_HALT_HOLDS_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !warm_done) |=> $stable(mreg)); // R13

endmodule

// File: rtl/pmc_warm_cnt.sv
module pmc_warm_cnt #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt;

  assign done = run & tick & (cnt == limit - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (done)    cnt <= '0;
    else if (tick)    cnt <= cnt + ONE;
  end

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < limit)); // R6

endmodule

// File: rtl/pmc_stop_fsm.sv
module pmc_stop_fsm
  import pmc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     stop_req,
  input  logic     lvl_rel,
  input  logic     stop_pin,
  input  logic     warm_done,
  output stop_st_e state
);

  logic pin_q;
  logic pin_prev;
  logic release_hit;

  assign release_hit = lvl_rel ? pin_q : (pin_q & ~pin_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q    <= 1'b0;
      pin_prev <= 1'b0;
      state    <= ST_RUN;
    end else begin
      pin_q    <= stop_pin;
      pin_prev <= pin_q;
      unique case (state)
        ST_RUN:  if (stop_req)    state <= ST_STOP;
        ST_STOP: if (release_hit) state <= ST_WARM;
        ST_WARM: if (warm_done)   state <= ST_RUN;
        default:                  state <= ST_RUN;
      endcase
    end
  end

  AST_STOP_LEAVES_TO_WARM: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP) |=> (state == ST_STOP || state == ST_WARM)); // R4
  AST_LEVEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP && lvl_rel && pin_q) |=> (state == ST_WARM)); // R5

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned WU_SHIFT = 0,
  parameter int          CNT_W    = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       stop_pin,
  input  logic       wake_irq,
  input  logic       hf_tick,
  input  logic       lf_tick,
  output logic       hf_osc_en,
  output logic       lf_osc_en,
  output logic       sysclk_sel,
  output logic       cpu_run,
  output logic       periph_clk_en,
  output logic       port_oe,
  output logic       pin_hiz,
  output logic       sys_rst_req,
  output logic [2:0] mode_o
);

  modereg_t         mreg;
  clkreg_t          creg;
  stop_st_e         state;
  logic             in_run;
  logic             in_warm;
  logic             accept;
  logic             warm_done;
  logic             tgt_tick;
  logic [CNT_W-1:0] limit;

  assign in_run   = (state == ST_RUN);
  assign in_warm  = (state == ST_WARM);
  assign accept   = in_run & ~mreg.stop & ~creg.cpu_halt & ~creg.per_halt;
  assign tgt_tick = mreg.ret_slow ? lf_tick : hf_tick;
  assign limit    = CNT_W'(warm_ticks(mreg.ret_slow, mreg.wcode, WU_SHIFT));

  pmc_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (reg_we),
    .sel       (reg_sel),
    .wdata     (reg_wdata),
    .accept    (accept),
    .wake_irq  (wake_irq),
    .wake_ok   (in_run),
    .warm_done (warm_done),
    .rdata     (reg_rdata),
    .mreg      (mreg),
    .creg      (creg),
    .rst_req   (sys_rst_req)
  );

  pmc_stop_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_req  (mreg.stop),
    .lvl_rel   (mreg.lvl_rel),
    .stop_pin  (stop_pin),
    .warm_done (warm_done),
    .state     (state)
  );

  pmc_warm_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (in_warm),
    .tick  (tgt_tick),
    .limit (limit),
    .done  (warm_done)
  );

  always_comb begin
    hf_osc_en     = in_run ? creg.hf_on : (in_warm & ~mreg.ret_slow);
    lf_osc_en     = in_run ? creg.lf_on : (in_warm &  mreg.ret_slow);
    sysclk_sel    = creg.clk_slow;
    cpu_run       = in_run & ~creg.cpu_halt & ~creg.per_halt;
    periph_clk_en = in_run & ~creg.per_halt;
    port_oe       = in_run ? 1'b1 : mreg.hold;
    pin_hiz       = ~in_run;
    if (state == ST_STOP)                    mode_o = MD_STOP;
    else if (in_warm)                        mode_o = MD_WARM;
    else if (creg.cpu_halt | creg.per_halt)  mode_o = creg.clk_slow ? MD_HALTS : MD_HALTF;
    else                                     mode_o = creg.clk_slow ? MD_SLOW : MD_FAST;
  end

  AST_OSC_OFF_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MD_STOP) |-> (!hf_osc_en && !lf_osc_en && !cpu_run)); // R3
  AST_WARM_ENDS_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    warm_done |=> (mode_o == (mreg.ret_slow ? MD_SLOW : MD_FAST) && !mreg.stop)); // R7
  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MD_STOP) |-> (port_oe == mreg.hold && pin_hiz)); // R9

endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int unsigned SHIFT = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       stop_pin = 1'b0;
  logic       wake_irq = 1'b0;
  logic       hf_tick = 1'b0;
  logic       lf_tick = 1'b0;
  logic       hf_osc_en, lf_osc_en, sysclk_sel, cpu_run, periph_clk_en;
  logic       port_oe, pin_hiz, sys_rst_req;
  logic [2:0] mode_o;

  int total = 0;
  int fails = 0;
  int seen  = 0;
  logic tgt_slow = 1'b0;
  logic [7:0] exp_m = 8'h00;
  logic [7:0] exp_c = 8'h80;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl #(.WU_SHIFT(SHIFT), .CNT_W(18)) u_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stop_pin(stop_pin),
    .wake_irq(wake_irq), .hf_tick(hf_tick), .lf_tick(lf_tick),
    .hf_osc_en(hf_osc_en), .lf_osc_en(lf_osc_en), .sysclk_sel(sysclk_sel),
    .cpu_run(cpu_run), .periph_clk_en(periph_clk_en), .port_oe(port_oe),
    .pin_hiz(pin_hiz), .sys_rst_req(sys_rst_req), .mode_o(mode_o)
  );

  function automatic int exp_ticks(input logic slow, input logic [1:0] code);
    int e;
    int m;
    if (slow) e = (code == 2'd0 || code == 2'd1) ? 13 : 6;
    else      e = (code == 2'd0 || code == 2'd1) ? 16 : 14;
    m = (code == 2'd0 || code == 2'd2) ? 3 : 1;
    e = (e > int'(SHIFT)) ? e - int'(SHIFT) : 0;
    return m * (1 << e);
  endfunction

  function automatic logic bad_clk(input logic [7:0] v);
    return (!v[7] && !v[6]) || (!v[7] && !v[5]) || (!v[6] && v[5]);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // Tick generator and warm-up tick tally (only the target oscillator's ticks count).
  initial begin
    forever begin
      logic hb, lb;
      @(negedge clk);
      hb = ($urandom % 2) == 0;
      lb = ($urandom % 3) == 0;
      hf_tick = hb;
      lf_tick = lb;
      if (mode_o == 3'd5 && (tgt_slow ? lb : hb)) seen++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic run_stop(input logic lvl, input logic slow, input logic hold,
                          input logic [1:0] code, input logic pin_hi);
    logic [7:0] d;
    logic [7:0] mv;
    int guard;
    wr(1'b1, 8'hC0);
    stop_pin = pin_hi;
    cyc(3);
    mv = {1'b1, lvl, slow, hold, code, 2'b00};
    wr(1'b0, mv);
    cyc(2);
    chk("R3 mode", mode_o, 3'd4);
    chk("R3 osc", {hf_osc_en, lf_osc_en, cpu_run, periph_clk_en}, 4'b0000);
    chk("R9 port_oe", port_oe, hold);
    chk("R9 pin_hiz", pin_hiz, 1'b1);
    wr(1'b0, 8'h00);
    rd(1'b0, d);
    chk("R13 write in STOP", d, mv);
    if (!lvl) begin
      cyc(6);
      chk("R4 no edge stays", mode_o, 3'd4);
      if (pin_hi) begin
        stop_pin = 1'b0;
        cyc(3);
        chk("R4 falling stays", mode_o, 3'd4);
      end
    end
    seen = 0;
    tgt_slow = slow;
    stop_pin = 1'b1;
    guard = 0;
    cyc(1);
    while ((mode_o == 3'd4 || mode_o == 3'd5) && guard < 4000) begin
      if (mode_o == 3'd5) chk(lvl ? "R5 warm osc" : "R4 warm osc",
                              {hf_osc_en, lf_osc_en}, {~slow, slow});
      cyc(1);
      guard++;
    end
    chk("R6 warm ticks", seen, exp_ticks(slow, code));
    chk("R7 mode", mode_o, {2'b00, slow});
    rd(1'b1, d);
    chk("R7 clk reg", d, slow ? 8'h60 : 8'h80);
    rd(1'b0, d);
    chk("R7 stop cleared", d, {1'b0, lvl, slow, hold, code, 2'b00});
    chk("R9 port after", {port_oe, pin_hiz}, 2'b10);
    stop_pin = 1'b0;
    cyc(2);
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4711));
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    rd(1'b0, d); chk("R1 reg0", d, 8'h00);
    rd(1'b1, d); chk("R1 reg1", d, 8'h80);
    chk("R1 mode", mode_o, 3'd0);
    chk("R1 outs", {hf_osc_en, lf_osc_en, cpu_run, periph_clk_en, port_oe, pin_hiz, sys_rst_req},
        7'b1011100);

    // R2 readback with undefined bits forced to zero
    wr(1'b0, 8'h7F); rd(1'b0, d); chk("R2 reg0", d, 8'h7C);
    wr(1'b1, 8'hCB); rd(1'b1, d); chk("R2 reg1", d, 8'hC0);
    chk("R2 no reset", sys_rst_req, 1'b0);

    // STOP directed corners
    run_stop(1'b0, 1'b0, 1'b1, 2'd0, 1'b1);
    run_stop(1'b0, 1'b1, 1'b0, 2'd1, 1'b0);
    run_stop(1'b1, 1'b0, 1'b0, 2'd2, 1'b0);
    run_stop(1'b1, 1'b1, 1'b1, 2'd3, 1'b0);
    // STOP random settings
    for (int i = 0; i < 8; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      run_stop(r[0], r[1], r[2], 2'($urandom), r[3] & ~r[0]);
    end

    // R8 reset pin during STOP, slow return selected
    wr(1'b1, 8'hC0);
    wr(1'b0, 8'hA0);
    cyc(2);
    chk("R8 in stop", mode_o, 3'd4);
    rst_n = 1'b0; cyc(1); rst_n = 1'b1; cyc(2);
    chk("R8 mode", mode_o, 3'd0);
    rd(1'b1, d); chk("R8 reg1", d, 8'h80);
    rd(1'b0, d); chk("R8 reg0", d, 8'h00);

    // R10 illegal clock settings
    wr(1'b0, 8'h14);
    wr(1'b1, 8'h00);
    chk("R10 pulse both off", sys_rst_req, 1'b1);
    cyc(1);
    chk("R10 pulse ends", sys_rst_req, 1'b0);
    rd(1'b0, d); chk("R10 reg0 restored", d, 8'h00);
    wr(1'b1, 8'h40);
    chk("R10 fast off on fast", sys_rst_req, 1'b1);
    rd(1'b1, d); chk("R10 reg1 restored", d, 8'h80);
    wr(1'b1, 8'hA0);
    chk("R10 slow off on slow", sys_rst_req, 1'b1);
    wr(1'b1, 8'h60);
    chk("R10 legal slow", sys_rst_req, 1'b0);
    chk("R10 slow mode", {mode_o, sysclk_sel}, {3'd1, 1'b1});
    wr(1'b1, 8'h80);

    // R11 halts and wake
    wr(1'b1, 8'h90);
    chk("R11 cpu halt", {cpu_run, periph_clk_en, mode_o}, {2'b01, 3'd2});
    wr(1'b0, 8'h10);
    rd(1'b0, d); chk("R13 write in halt", d, 8'h00);
    wake_irq = 1'b1; cyc(1); wake_irq = 1'b0;
    chk("R11 wake", {cpu_run, periph_clk_en, mode_o}, {2'b11, 3'd0});
    rd(1'b1, d); chk("R11 bit cleared", d, 8'h80);
    wr(1'b1, 8'hE4);
    chk("R11 periph halt slow", {cpu_run, periph_clk_en, mode_o}, {2'b00, 3'd3});
    wake_irq = 1'b1; cyc(1); wake_irq = 1'b0;
    chk("R11 wake2", {cpu_run, periph_clk_en}, 2'b11);
    // R12 both halts written
    wr(1'b1, 8'h94);
    rd(1'b1, d); chk("R12 tghalt dropped", d, 8'h90);
    chk("R12 periph runs", periph_clk_en, 1'b1);
    wake_irq = 1'b1; cyc(1); wake_irq = 1'b0;

    // Constrained random register traffic
    exp_m = 8'h00;
    wr(1'b1, 8'h80);
    exp_c = 8'h80;
    for (int i = 0; i < 40; i++) begin
      logic [7:0] v;
      logic s;
      v = 8'($urandom);
      s = 1'($urandom);
      if (s) begin
        v = v & 8'hEB;
        wr(1'b1, v);
        if (bad_clk(v)) begin
          chk("R10 random pulse", sys_rst_req, 1'b1);
          exp_c = 8'h80; exp_m = 8'h00;
        end else begin
          chk("R10 random no pulse", sys_rst_req, 1'b0);
          exp_c = v & 8'hE0;
        end
      end else begin
        v = v & 8'h7F;
        wr(1'b0, v);
        exp_m = v & 8'h7C;
      end
      rd(1'b0, d); chk("R2 random reg0", d, exp_m);
      rd(1'b1, d); chk("R2 random reg1", d, exp_c);
      chk("R2 random mode", mode_o, {2'b00, exp_c[5]});
    end

    finish_run();
  end

endmodule